// File: doc/BRIEF.md
# Timer Capture Unit with Period Reset

This block is an up-counter for measuring the timing of an external signal. While software has the unit enabled and set to capture mode, the counter advances by one on every clock. When the chosen transition appears on the external input pin, the unit copies the current count into a capture register and raises a capture interrupt flag. The counter keeps running through captures. Software reads the count and the flag, and takes the difference between two captures to get a pulse width.

A period register sets the highest value the count reaches. When the count equals that value, the counter goes back to zero on the next clock and a separate period interrupt flag is raised. Software can count these period flags to measure pulses longer than one counter cycle. Both flags stay set until software writes a one to clear them.

The counter has a two-state controller. In `CNT_IDLE` the count is held at zero. The transition *start* (enable high and the mode field equal to the capture code) moves it to `CNT_RUN`. In `CNT_RUN` the count steps up or wraps. The transition *stop* (enable low or the mode field changed) returns it to `CNT_IDLE`.

Top module: `tmr_capture_unit`

## Requirements
- R1: After reset, the count, the capture register and both interrupt flags are zero.
- R2: The unit counts and captures only when the mode field is 2'b01. For any other mode value the count stays at zero and no capture takes place.
- R3: On the clock edge that sees enable high (in capture mode), the controller enters the run state with the count at zero. The count then rises by one on each later edge. On the first edge that sees enable low, the count returns to zero, and it stays at zero while enable is low.
- R4: The edge-select field chooses the capture trigger: 2'b00 is a rising edge, 2'b01 is a falling edge and 2'b10 is either edge of the pin.
- R5: With the edge-select field at 2'b11, pin transitions capture nothing and set no flag, while the count keeps advancing.
- R6: The pin passes through two synchroniser flops and is then compared with its previous sample. If the pin changes before clock edge k, the capture register and the capture flag update on edge k+2, and the value stored is the count held just before that edge.
- R7: A capture neither stops nor resets the count. The count keeps rising by one per cycle across a capture.
- R8: When the count equals the period value, the next edge sets the count to zero and sets the period flag. The count therefore cycles through 0 to period.
- R9: If a capture and a period match occur on the same edge, the capture register receives the period value (the count before the reset). Both flags are set.
- R10: Each flag stays set until a one-cycle clear pulse on its own clear input. A set on the same edge as a clear wins.
- R11: The clear-on-match and duplex control inputs have no effect on counting, wrapping or capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Counter run enable |
| mode_i | input | 2 | Timer mode field; 2'b01 selects capture |
| edge_sel_i | input | 2 | Capture trigger select |
| clr_on_match_i | input | 1 | Clear-on-match select, ignored in this mode |
| duplex_i | input | 1 | Duplex select, ignored in this mode |
| period_i | input | CNT_W | Period compare value |
| cap_pin_i | input | 1 | Asynchronous external capture input |
| cap_irq_clr_i | input | 1 | Write-one-to-clear pulse for the capture flag |
| per_irq_clr_i | input | 1 | Write-one-to-clear pulse for the period flag |
| count_o | output | CNT_W | Current count |
| capture_o | output | CNT_W | Last captured count |
| cap_irq_o | output | 1 | Capture interrupt flag |
| per_irq_o | output | 1 | Period-match interrupt flag |

## Verification
A pin change driven at a falling clock edge appears in the capture register and the capture flag after three rising edges. The bench therefore waits three edges and samples on the following falling edge. The value it expects is the count seen when it drove the pin plus two.

The count moves on every rising edge. After enable is raised, the count after N edges is N-1. A period match shows up as a zero count and a set flag one edge after the count equals the period.

Every check samples at a falling edge, halfway between the edges that move the design. The coincidence case starts from a count read at the ports, so the capture edge and the wrap edge fall in the same cycle.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    // Trigger codes carried on the edge-select field
    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_sel_e;

    // Mode-field code that selects capture operation
    localparam logic [1:0] MODE_CAPTURE = 2'b01;

    // Counter controller states
    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

endpackage

// File: rtl/tcu_edge_detect.sv
module tcu_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[TOP];
    end

    always_comb begin
        rise_o = chain_q[TOP] & ~prev_q;
        fall_o = ~chain_q[TOP] & prev_q;
    end

    // R6
    rise_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> prev_q);

endmodule

// File: rtl/tcu_counter.sv
module tcu_counter
    import tcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             active_o,
    output logic             match_o
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             run_ok;

    assign run_ok = enable_i && (mode_i == MODE_CAPTURE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_IDLE;
        else        state_q <= state_d;
    end

    // next state: start / stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (run_ok)  state_d = CNT_RUN;
            CNT_RUN:  if (!run_ok) state_d = CNT_IDLE;
            default:  state_d = CNT_IDLE;
        endcase
    end

    // outputs: count, activity and compare strobe
    always_comb begin
        active_o = (state_q == CNT_RUN) && run_ok;
        match_o  = active_o && (count_q == period_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        count_q <= '0;
        else if (match_o)  count_q <= '0;
        else if (active_o) count_q <= count_q + CNT_W'(1);
        else               count_q <= '0;
    end

    assign count_o = count_q;

    // R3
    idle_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (count_q == '0));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && run_ok && count_q != period_i)
            |=> (count_q == $past(count_q) + CNT_W'(1)));
    // R8
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_RUN && run_ok && count_q == period_i) |=> (count_q == '0));
    // R2
    other_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_CAPTURE) |=> (state_q == CNT_IDLE));

endmodule

// File: rtl/tcu_capture.sv
module tcu_capture
    import tcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             match_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             cap_clr_i,
    input  logic             per_clr_i,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cap_flag_o,
    output logic             per_flag_o
);
    logic [CNT_W-1:0] cap_val_q;
    logic             cap_flag_q, per_flag_q;
    logic             trig, fire;

    always_comb begin
        unique case (edge_sel_e'(edge_sel_i))
            EDGE_RISE: trig = rise_i;
            EDGE_FALL: trig = fall_i;
            EDGE_BOTH: trig = rise_i | fall_i;
            EDGE_OFF:  trig = 1'b0;
            default:   trig = 1'b0;
        endcase
        fire = active_i && trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_val_q <= '0;
        else if (fire) cap_val_q <= count_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_flag_q <= 1'b0;
            per_flag_q <= 1'b0;
        end else begin
            if (fire)           cap_flag_q <= 1'b1;
            else if (cap_clr_i) cap_flag_q <= 1'b0;
            if (match_i)        per_flag_q <= 1'b1;
            else if (per_clr_i) per_flag_q <= 1'b0;
        end
    end

    assign cap_val_o  = cap_val_q;
    assign cap_flag_o = cap_flag_q;
    assign per_flag_o = per_flag_q;

    // R5
    no_capture_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == EDGE_OFF) |=> $stable(cap_val_q));
    // R10
    cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_q && !cap_clr_i) |=> cap_flag_q);
    // R10
    per_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_flag_q && !per_clr_i) |=> per_flag_q);
    // R6
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_flag_q && cap_val_q == $past(count_i)));
    // R8
    per_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> per_flag_q);

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
    import tcu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [1:0]       mode_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             clr_on_match_i,
    input  logic             duplex_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             cap_pin_i,
    input  logic             cap_irq_clr_i,
    input  logic             per_irq_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] capture_o,
    output logic             cap_irq_o,
    output logic             per_irq_o
);
    logic rise, fall, active, match;

    tcu_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_pin_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    tcu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable_i),
        .mode_i   (mode_i),
        .period_i (period_i),
        .count_o  (count_o),
        .active_o (active),
        .match_o  (match)
    );

    tcu_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .edge_sel_i (edge_sel_i),
        .rise_i     (rise),
        .fall_i     (fall),
        .match_i    (match),
        .count_i    (count_o),
        .cap_clr_i  (cap_irq_clr_i),
        .per_clr_i  (per_irq_clr_i),
        .cap_val_o  (capture_o),
        .cap_flag_o (cap_irq_o),
        .per_flag_o (per_irq_o)
    );

    // R11
    ignored_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !match && (clr_on_match_i || duplex_i))
            |=> (count_o == $past(count_o) + CNT_W'(1)));

endmodule

// File: tb/tmr_capture_unit_bench.sv
module tmr_capture_unit_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable_i = 1'b0;
    logic [1:0]   mode_i = 2'b01;
    logic [1:0]   edge_sel_i = 2'b00;
    logic         clr_on_match_i = 1'b0;
    logic         duplex_i = 1'b0;
    logic [W-1:0] period_i = 16'd1000;
    logic         cap_pin_i = 1'b0;
    logic         cap_irq_clr_i = 1'b0;
    logic         per_irq_clr_i = 1'b0;
    logic [W-1:0] count_o, capture_o;
    logic         cap_irq_o, per_irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] c0;

    always #2 clk = ~clk;

    tmr_capture_unit #(.CNT_W(W)) u_tmr_capture_unit (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
        .edge_sel_i(edge_sel_i), .clr_on_match_i(clr_on_match_i), .duplex_i(duplex_i),
        .period_i(period_i), .cap_pin_i(cap_pin_i), .cap_irq_clr_i(cap_irq_clr_i),
        .per_irq_clr_i(per_irq_clr_i), .count_o(count_o), .capture_o(capture_o),
        .cap_irq_o(cap_irq_o), .per_irq_o(per_irq_o)
    );

    // {edge_sel[1:0], pin level, expected capture flag}
    localparam logic [3:0] VEC [8] = '{
        {2'b00, 1'b1, 1'b1}, {2'b00, 1'b0, 1'b0},
        {2'b01, 1'b1, 1'b0}, {2'b01, 1'b0, 1'b1},
        {2'b10, 1'b1, 1'b1}, {2'b10, 1'b0, 1'b1},
        {2'b11, 1'b1, 1'b0}, {2'b11, 1'b0, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        cap_irq_clr_i = 1'b1;
        per_irq_clr_i = 1'b1;
        tick(1);
        cap_irq_clr_i = 1'b0;
        per_irq_clr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 capture", capture_o, 0);
        chk("R1 cap flag", cap_irq_o, 0);
        chk("R1 per flag", per_irq_o, 0);

        // R2 other mode: no count, no capture
        mode_i = 2'b00;
        enable_i = 1'b1;
        tick(4);
        chk("R2 count held", count_o, 0);
        cap_pin_i = 1'b1;
        tick(3);
        chk("R2 no capture flag", cap_irq_o, 0);
        cap_pin_i = 1'b0;
        tick(3);
        enable_i = 1'b0;
        mode_i = 2'b01;
        tick(1);

        // R3 start: count after N edges is N-1
        enable_i = 1'b1;
        tick(5);
        chk("R3 count after start", count_o, 4);

        // R4/R5 edge-select table
        for (int i = 0; i < 8; i++) begin
            edge_sel_i = VEC[i][3:2];
            tick(1);
            cap_pin_i = VEC[i][1];
            tick(3);
            chk((VEC[i][3:2] == 2'b11) ? "R5 off code" : "R4 edge code", cap_irq_o, VEC[i][0]);
            clear_flags();
        end
        c0 = count_o;
        tick(1);
        chk("R5 count runs with capture off", count_o, c0 + 1);

        // R6/R7 capture value and counter continuity
        edge_sel_i = 2'b00;
        tick(1);
        c0 = count_o;
        cap_pin_i = 1'b1;
        tick(3);
        chk("R6 capture value", capture_o, c0 + 2);
        chk("R6 capture flag", cap_irq_o, 1);
        chk("R7 count continues", count_o, c0 + 3);

        // R10 sticky then cleared
        tick(5);
        chk("R10 flag sticky", cap_irq_o, 1);
        cap_irq_clr_i = 1'b1;
        tick(1);
        cap_irq_clr_i = 1'b0;
        chk("R10 flag cleared", cap_irq_o, 0);
        cap_pin_i = 1'b0;
        tick(3);

        // R3 stop
        enable_i = 1'b0;
        tick(1);
        chk("R3 zero after stop", count_o, 0);
        tick(3);
        chk("R3 held at zero", count_o, 0);

        // R8 period wrap
        period_i = 16'd5;
        clear_flags();
        enable_i = 1'b1;
        tick(6);
        chk("R8 count at period", count_o, 5);
        chk("R8 no flag yet", per_irq_o, 0);
        tick(1);
        chk("R8 wrapped", count_o, 0);
        chk("R8 period flag", per_irq_o, 1);

        // R11 ignored control bits
        enable_i = 1'b0;
        clr_on_match_i = 1'b1;
        duplex_i = 1'b1;
        tick(1);
        clear_flags();
        enable_i = 1'b1;
        tick(6);
        chk("R11 count at period", count_o, 5);
        tick(1);
        chk("R11 wrap unchanged", count_o, 0);
        tick(3);
        chk("R11 count after wrap", count_o, 3);
        clr_on_match_i = 1'b0;
        duplex_i = 1'b0;

        // R9 capture on the wrap edge
        enable_i = 1'b0;
        period_i = 16'd20;
        tick(1);
        clear_flags();
        enable_i = 1'b1;
        for (int k = 0; k < 40 && count_o != 16'd18; k++) tick(1);
        cap_pin_i = 1'b1;
        tick(3);
        chk("R9 captured period value", capture_o, 20);
        chk("R9 count reset", count_o, 0);
        chk("R9 period flag", per_irq_o, 1);
        chk("R9 capture flag", cap_irq_o, 1);

        finish_run();
    end
endmodule